// File: doc/BRIEF.md
# Four-Rail Power Sequencer Controller

This block turns four downstream power converters on and off in a fixed order. It watches a supply-good flag and a sequence-request input. When both are valid, a start delay confirms that the supply stays good. Rail A then turns on, followed by B, C and D. Each of B, C and D waits its own programmable delay before it turns on.

When the sequence request is withdrawn, the block runs the start delay once more. It then turns the rails off in the order D, C, B, A, reusing the per-stage delays. Losing the supply-good flag at any point drops all four rails in the same cycle.

All delays are counts of clock cycles and are taken from input ports. One shared counter times every stage. The supply-good and sequence-request inputs pass through two-flop synchronizers before the state machine sees them. The polarity of the enable outputs and the polarity of the sequence-request input are each set by a parameter.

Top module: `pwr_seq4`

## Requirements
- R1: While `por_ok` is low, all four enables stay at their reset level, whatever the other inputs do. When `por_ok` rises with `comply` and the active sequence request already settled, enable A asserts `dly_start`+2 clock edges later.
- R2: Start-up begins only when the synchronized `comply` and the active sequence request are both true. Counting from the first clock edge after both inputs change, enable A asserts after `dly_start`+4 edges. Dropping the sequence request during the start delay abandons the start-up.
- R3: If `comply` drops during the start delay, the start-up is abandoned and the timer is cleared. When `comply` returns, a new start begins from zero, and A asserts `dly_start`+4 edges after the return.
- R4: The turn-on order is A, B, C, D. B asserts `dly_b`+1 edges after A, C asserts `dly_c`+1 edges after B, and D asserts `dly_d`+1 edges after C. The set of active enables is always one of {}, {A}, {A,B}, {A,B,C} or {A,B,C,D}.
- R5: When the sequence request is deasserted with all four rails on, D turns off `dly_start`+4 edges later. C turns off `dly_d`+1 edges after D, B turns off `dly_c`+1 edges after C, and A turns off `dly_b`+1 edges after B. Every change to a non-empty set of enables changes exactly one rail.
- R6: If `comply` drops at any time, all active enables return to their reset level on the same edge, 3 edges after the drop, with no staged delay.
- R7: With `ACT_HIGH`=1, an active enable is 1 and a reset enable is 0. With `ACT_HIGH`=0, the levels are inverted. `en_o` bit 0 is rail A and bit 3 is rail D.
- R8: With `SEQ_ACT_HIGH`=1, `seq_en` high requests the on sequence. With `SEQ_ACT_HIGH`=0, `seq_en` low requests it. Apart from that, the behaviour is identical.
- R9: A delay count of zero advances to the next stage on the next clock edge, so that stage lasts exactly one cycle.
- R10: If the sequence request is reasserted during the off sequence, the off sequence still runs until A is off. A fresh on sequence then begins, and A asserts again `dly_start`+2 edges after it turned off.
- R11: `busy` is high exactly while a start delay or a stage delay is counting. It is low when all rails are off and idle, and low when all four rails are on and steady. Every change of the enables to a non-empty set follows a cycle with `busy` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| por_ok | input | 1 | Power-on-reset satisfied |
| comply | input | 1 | Supply within its valid window (asynchronous) |
| seq_en | input | 1 | Sequence request, polarity set by SEQ_ACT_HIGH (asynchronous) |
| dly_start | input | CNT_W | Start delay count |
| dly_b | input | CNT_W | Delay count for the A-to-B stage |
| dly_c | input | CNT_W | Delay count for the B-to-C stage |
| dly_d | input | CNT_W | Delay count for the C-to-D stage |
| en_o | output | 4 | Rail enables, bit 0 = A, polarity set by ACT_HIGH |
| busy | output | 1 | A delay is counting |

## Verification
The bench measures the exact edge count to every on and off transition for several delay sets, including all-zero delays. A timer that is off by one, or that is not cleared at each stage, therefore shows up as a wrong count.

It drops compliance in the middle of the start delay and then restores it. A design that kept its partial count would assert A too early.

It also drops compliance in the middle of the on sequence and after the on sequence completes. A staged shutdown there would leave rails high after the third edge.

It reasserts the sequence request during the off sequence. A design that reversed direction early would never turn A off.

A second instance with both polarities inverted is compared against the first on every sample.

// File: rtl/pwr_seq4_pkg.sv
package pwr_seq4_pkg;
   localparam int RAILS = 4;

   typedef enum logic [3:0] {
      ST_OFF,
      ST_START,
      ST_ON_A,
      ST_ON_B,
      ST_ON_C,
      ST_ALL,
      ST_STOP,
      ST_OFF_D,
      ST_OFF_C,
      ST_OFF_B
   } seq_state_t;

   function automatic logic [RAILS-1:0] rail_mask(seq_state_t s);
      case (s)
         ST_ON_A, ST_OFF_B:  rail_mask = 4'b0001;
         ST_ON_B, ST_OFF_C:  rail_mask = 4'b0011;
         ST_ON_C, ST_OFF_D:  rail_mask = 4'b0111;
         ST_ALL,  ST_STOP:   rail_mask = 4'b1111;
         default:            rail_mask = 4'b0000;
      endcase
   endfunction

   function automatic logic is_timed(seq_state_t s);
      is_timed = !(s == ST_OFF || s == ST_ALL);
   endfunction
endpackage

// File: rtl/pwr_seq4_sync.sv
module pwr_seq4_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   genvar i;
   generate
      for (i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n)
               chain[i] <= '0;
            else if (i == 0)
               chain[i] <= d;
            else
               chain[i] <= chain[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pwr_seq4_timer.sv
module pwr_seq4_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [CNT_W-1:0] limit,
   output logic             hit
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart || !run)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   assign hit = run && (cnt == limit);
endmodule

// File: rtl/pwr_seq4_fsm.sv
module pwr_seq4_fsm
   import pwr_seq4_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             por_ok,
   input  logic             comply,
   input  logic             seq_req,
   input  logic             hit,
   input  logic [CNT_W-1:0] dly_start,
   input  logic [CNT_W-1:0] dly_b,
   input  logic [CNT_W-1:0] dly_c,
   input  logic [CNT_W-1:0] dly_d,
   output logic [CNT_W-1:0] limit,
   output logic             run,
   output logic             restart,
   output logic [RAILS-1:0] rails
);
   seq_state_t st, st_nxt;

   always_comb begin
      st_nxt = st;
      case (st)
         ST_OFF:   if (comply && seq_req) st_nxt = ST_START;
         ST_START: if (!seq_req) st_nxt = ST_OFF;
                   else if (hit) st_nxt = ST_ON_A;
         ST_ON_A:  if (hit) st_nxt = ST_ON_B;
         ST_ON_B:  if (hit) st_nxt = ST_ON_C;
         ST_ON_C:  if (hit) st_nxt = ST_ALL;
         ST_ALL:   if (!seq_req) st_nxt = ST_STOP;
         ST_STOP:  if (hit) st_nxt = ST_OFF_D;
         ST_OFF_D: if (hit) st_nxt = ST_OFF_C;
         ST_OFF_C: if (hit) st_nxt = ST_OFF_B;
         ST_OFF_B: if (hit) st_nxt = ST_OFF;
         default:  st_nxt = ST_OFF;
      endcase
      if (!comply || !por_ok)
         st_nxt = ST_OFF;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         st <= ST_OFF;
      else
         st <= st_nxt;
   end

   always_comb begin
      case (st)
         ST_ON_A, ST_OFF_B: limit = dly_b;
         ST_ON_B, ST_OFF_C: limit = dly_c;
         ST_ON_C, ST_OFF_D: limit = dly_d;
         default:           limit = dly_start;
      endcase
   end

   assign run     = is_timed(st);
   assign restart = (st_nxt != st);
   assign rails   = rail_mask(st);
endmodule

// File: rtl/pwr_seq4.sv
module pwr_seq4
   import pwr_seq4_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int SYNC_STAGES  = 2,
   parameter bit ACT_HIGH     = 1'b1,
   parameter bit SEQ_ACT_HIGH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             por_ok,
   input  logic             comply,
   input  logic             seq_en,
   input  logic [CNT_W-1:0] dly_start,
   input  logic [CNT_W-1:0] dly_b,
   input  logic [CNT_W-1:0] dly_c,
   input  logic [CNT_W-1:0] dly_d,
   output logic [3:0]       en_o,
   output logic             busy
);
   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("pwr_seq4: CNT_W out of range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pwr_seq4: SYNC_STAGES below 2");
      end
   endgenerate

   logic [1:0]       sync_q;
   logic             comply_s, seq_req;
   logic             hit, run, restart;
   logic [CNT_W-1:0] limit;
   logic [RAILS-1:0] rails, lvl;

   pwr_seq4_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({seq_en, comply}), .q(sync_q)
   );

   assign comply_s = sync_q[0];

   generate
      if (SEQ_ACT_HIGH) begin : g_seq_hi
         assign seq_req = sync_q[1];
      end else begin : g_seq_lo
         assign seq_req = ~sync_q[1];
      end
   endgenerate

   pwr_seq4_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
      .limit(limit), .hit(hit)
   );

   pwr_seq4_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .comply(comply_s),
      .seq_req(seq_req), .hit(hit), .dly_start(dly_start), .dly_b(dly_b),
      .dly_c(dly_c), .dly_d(dly_d), .limit(limit), .run(run),
      .restart(restart), .rails(rails)
   );

   assign lvl  = por_ok ? rails : '0;
   assign busy = run;

   generate
      if (ACT_HIGH) begin : g_out_hi
         assign en_o = lvl;
      end else begin : g_out_lo
         assign en_o = ~lvl;
      end
   endgenerate
endmodule

// File: rtl/pwr_seq4_chk.sv
module pwr_seq4_chk #(
   parameter bit ACT_HIGH = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       por_ok,
   input logic       comply,
   input logic [3:0] en_o,
   input logic       busy
);
   logic [3:0] act;
   logic [2:0] hist;
   logic [1:0] since;

   assign act = ACT_HIGH ? en_o : ~en_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist  <= 3'b111;
         since <= '0;
      end else begin
         hist <= {hist[1:0], comply};
         if (since != 2'd3) since <= since + 1'b1;
      end
   end

   AST_POR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !por_ok |-> act == 4'b0000);  // R1

   AST_ON_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      act inside {4'b0000, 4'b0001, 4'b0011, 4'b0111, 4'b1111});  // R4

   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (since != 2'd0 && act != 4'b0000) |-> $countones(act ^ $past(act)) <= 1);  // R5

   AST_DROP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (since == 2'd3 && hist == 3'b000) |-> act == 4'b0000);  // R6

   AST_TIMED_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (since != 2'd0 && act != 4'b0000 && act != $past(act)) |-> $past(busy));  // R11
endmodule

bind pwr_seq4 pwr_seq4_chk #(.ACT_HIGH(ACT_HIGH)) u_chk (
   .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .comply(comply),
   .en_o(en_o), .busy(busy)
);

// File: tb/pwr_seq4_bench.sv
module pwr_seq4_bench;
   localparam int W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic por_ok = 1'b1;
   logic comply = 1'b0;
   logic seq = 1'b0;
   logic [W-1:0] ds = '0, db = '0, dc = '0, dd = '0;
   logic [3:0] en, en_inv;
   logic busy, busy_inv;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #2.5 clk = ~clk;

   pwr_seq4 #(.CNT_W(W)) u_pwr_seq4 (
      .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .comply(comply), .seq_en(seq),
      .dly_start(ds), .dly_b(db), .dly_c(dc), .dly_d(dd), .en_o(en), .busy(busy)
   );

   pwr_seq4 #(.CNT_W(W), .ACT_HIGH(1'b0), .SEQ_ACT_HIGH(1'b0)) u_inv (
      .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .comply(comply), .seq_en(~seq),
      .dly_start(ds), .dly_b(db), .dly_c(dc), .dly_d(dd), .en_o(en_inv), .busy(busy_inv)
   );

   // rows: {start, b, c, d}
   localparam int NROW = 4;
   localparam int ROWS [NROW][4] = '{
      '{0, 0, 0, 0},
      '{3, 1, 2, 5},
      '{7, 4, 0, 2},
      '{1, 6, 3, 0}
   };

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // counts edges until rail idx reaches level lvl; compares the inverted instance
   task automatic measure(input int idx, input bit lvl, input int exp, input string req);
      int n = 0;
      bit pol_ok = 1'b1;
      while (n < 3000) begin
         tick();
         n++;
         if (en_inv != ~en || busy_inv != busy) pol_ok = 1'b0;
         if (en[idx] == lvl) break;
      end
      check(req, n, exp);
      check("R7 R8 inverted instance", int'(pol_ok), 1);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; comply = 1'b0; seq = 1'b0; por_ok = 1'b1;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic set_dly(input int s, input int b, input int c, input int d);
      ds = W'(s); db = W'(b); dc = W'(c); dd = W'(d);
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      check("R1 reset enables", int'(en), 0);
      check("R11 reset busy", int'(busy), 0);
      check("R7 reset inverted level", int'(en_inv), 15);

      // vector table: full on and off sequences
      for (int r = 0; r < NROW; r++) begin
         do_reset();
         set_dly(ROWS[r][0], ROWS[r][1], ROWS[r][2], ROWS[r][3]);
         comply = 1'b1; seq = 1'b1;
         measure(0, 1'b1, ROWS[r][0] + 4, "R2 A on");
         measure(1, 1'b1, ROWS[r][1] + 1, "R4 R9 B on");
         measure(2, 1'b1, ROWS[r][2] + 1, "R4 R9 C on");
         measure(3, 1'b1, ROWS[r][3] + 1, "R4 R9 D on");
         tick();
         check("R11 idle when all on", int'(busy), 0);
         check("R4 all on", int'(en), 15);
         seq = 1'b0;
         measure(3, 1'b0, ROWS[r][0] + 4, "R5 D off");
         measure(2, 1'b0, ROWS[r][3] + 1, "R5 R9 C off");
         measure(1, 1'b0, ROWS[r][2] + 1, "R5 R9 B off");
         measure(0, 1'b0, ROWS[r][1] + 1, "R5 R9 A off");
      end

      // power-on-reset hold
      do_reset();
      set_dly(2, 1, 1, 1);
      por_ok = 1'b0; comply = 1'b1; seq = 1'b1;
      repeat (40) tick();
      check("R1 held while por low", int'(en), 0);
      check("R1 not busy while por low", int'(busy), 0);
      por_ok = 1'b1;
      measure(0, 1'b1, 2 + 2, "R1 A after por");

      // compliance lost during start delay
      do_reset();
      set_dly(10, 1, 1, 1);
      comply = 1'b1; seq = 1'b1;
      repeat (5) tick();
      check("R11 busy in start delay", int'(busy), 1);
      comply = 1'b0;
      repeat (3) tick();
      check("R3 busy cleared after drop", int'(busy), 0);
      repeat (10) tick();
      check("R3 A stays off", int'(en), 0);
      comply = 1'b1;
      measure(0, 1'b1, 10 + 4, "R3 fresh start");

      // sequence request dropped during start delay
      do_reset();
      set_dly(20, 1, 1, 1);
      comply = 1'b1; seq = 1'b1;
      repeat (6) tick();
      seq = 1'b0;
      repeat (30) tick();
      check("R2 start abandoned", int'(en), 0);
      check("R2 idle after abandon", int'(busy), 0);

      // compliance lost mid on-sequence
      do_reset();
      set_dly(1, 2, 50, 2);
      comply = 1'b1; seq = 1'b1;
      measure(0, 1'b1, 5, "R2 A on");
      measure(1, 1'b1, 3, "R4 B on");
      comply = 1'b0;
      tick(); tick();
      check("R6 still up before sync", int'(en), 3);
      tick();
      check("R6 mid-sequence drop", int'(en), 0);

      // compliance lost after all on
      do_reset();
      set_dly(0, 0, 0, 0);
      comply = 1'b1; seq = 1'b1;
      repeat (12) tick();
      check("R4 all on", int'(en), 15);
      comply = 1'b0;
      tick(); tick();
      check("R6 still up before sync", int'(en), 15);
      tick();
      check("R6 simultaneous drop", int'(en), 0);

      // request reasserted during off sequence
      do_reset();
      set_dly(3, 2, 2, 2);
      comply = 1'b1; seq = 1'b1;
      repeat (30) tick();
      check("R4 all on", int'(en), 15);
      seq = 1'b0;
      measure(3, 1'b0, 3 + 4, "R10 D off");
      seq = 1'b1;
      measure(2, 1'b0, 3, "R10 C off");
      measure(1, 1'b0, 3, "R10 B off");
      measure(0, 1'b0, 3, "R10 A off");
      measure(0, 1'b1, 3 + 2, "R10 restart A on");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule